// File: doc/BRIEF.md
# I/O Peripheral Base Address Decoder

This block turns the configuration bytes of four legacy I/O functions into host bus decode. The functions are a floppy controller, two serial ports and a parallel port. For each one it builds the base address from the programmed byte and aligns it to the window of that function. A base that falls outside the legal I/O range is replaced by a fixed fallback address that belongs to that function. The block also applies the disable controls and resolves the interrupt numbers. The floppy controller, the serial ports, the parallel port and the interrupt routing all live outside the block.

The decoded bases, the valid flags and the interrupt numbers are held in registers. They load from the configuration inputs on every rising clock edge and take fixed default values while reset is held. The chip selects are combinational from the host address and the registered decode. At most one chip select is active at a time. The priority is floppy first, then serial A, then serial B, then parallel.

Top module: `periph_base_decoder`

## Requirements
- R1: The floppy base is the configuration byte bits [7:2] placed at address bits [9:4], with bits [3:0] zero. When the result is below 0x100 or above 0x3F0, the base is 0x3F0 instead. The floppy function is always valid and decodes a 16-byte window.
- R2: The parallel base is the configuration byte shifted left by two. It is aligned to 4 bytes in standard mode and to 8 bytes in EPP mode, and the window has the same size as the alignment. When the aligned result is below 0x100 or above 0x3FF, the base is 0x378.
- R3: EPP mode is `cfg_ext_en & cfg_epp_sel`. ECP mode is `cfg_ext_en & cfg_ecp_sel`, and it adds a second parallel window at the parallel base with address bit 10 set. When `cfg_ext_en` is 0, both mode selects have no effect on the decode.
- R4: Each serial base is its configuration byte bits [7:1] placed at address bits [9:3], with bits [2:0] zero, and decodes an 8-byte window. When the result is below 0x100 or above 0x3F8, serial A falls back to 0x3F8 and serial B falls back to 0x2F8.
- R5: `cfg_lpt_dis` clears the parallel valid flag. A serial valid flag is cleared by its disable input, and also when bits [7:6] of its address byte are both 0. A device that is not valid never asserts its chip select, but its base output still shows the decoded address.
- R6: `cfg_uart_irq` bits [7:4] give the serial A interrupt and bits [3:0] give the serial B interrupt. A zero nibble becomes 4 for serial A and 3 for serial B. A serial port that is not valid reports 15, which means no interrupt.
- R7: When `cfg_lpt_irq` bits [3:0] are nonzero, the parallel interrupt is `cfg_lpt_irq` bits [7:5] as a number from 0 to 7. When those bits are zero, or when the port is not valid, the parallel interrupt is 15.
- R8: A chip select is asserted while `host_addr` lies inside the window of a valid device. At most one chip select is asserted at a time, with the priority floppy, then serial A, then serial B, then parallel.
- R9: While reset is held, the outputs are: floppy base 0x3F0; parallel base 0x378, valid, standard 4-byte window, no ECP window, interrupt 15; serial A base 0x3F8, valid, interrupt 4; serial B base 0x2F8, valid, interrupt 3.
- R10: A change on a configuration input shows on the decoded outputs after the next rising clock edge, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fdc_base | input | 8 | Floppy address byte |
| cfg_lpt_base | input | 8 | Parallel address byte |
| cfg_uart_a_base | input | 8 | Serial A address byte |
| cfg_uart_b_base | input | 8 | Serial B address byte |
| cfg_ext_en | input | 1 | Enables the extended parallel modes |
| cfg_epp_sel | input | 1 | Selects the 8-byte parallel window |
| cfg_ecp_sel | input | 1 | Adds the parallel window with A10 set |
| cfg_lpt_dis | input | 1 | Disables the parallel port |
| cfg_uart_a_dis | input | 1 | Disables serial A |
| cfg_uart_b_dis | input | 1 | Disables serial B |
| cfg_uart_irq | input | 8 | Serial interrupts: A in [7:4], B in [3:0] |
| cfg_lpt_irq | input | 8 | Parallel interrupt number [7:5] and enable field [3:0] |
| host_addr | input | ADDR_W (11) | Host I/O address |
| fdc_base | output | ADDR_W | Decoded floppy base |
| lpt_base | output | ADDR_W | Decoded parallel base |
| uart_a_base | output | ADDR_W | Decoded serial A base |
| uart_b_base | output | ADDR_W | Decoded serial B base |
| fdc_valid | output | 1 | Floppy decode active |
| lpt_valid | output | 1 | Parallel decode active |
| uart_a_valid | output | 1 | Serial A decode active |
| uart_b_valid | output | 1 | Serial B decode active |
| lpt_irq | output | IRQ_W (4) | Parallel interrupt, 15 for none |
| uart_a_irq | output | IRQ_W | Serial A interrupt, 15 for none |
| uart_b_irq | output | IRQ_W | Serial B interrupt, 15 for none |
| cs_fdc | output | 1 | Floppy chip select |
| cs_uart_a | output | 1 | Serial A chip select |
| cs_uart_b | output | 1 | Serial B chip select |
| cs_lpt | output | 1 | Parallel chip select, either window |

## Verification
The assertions check a set of properties on every cycle:
- The chip selects are mutually exclusive.
- A chip select appears only for a valid device.
- The floppy base stays aligned and inside its legal range.
- A legal floppy byte shows at the base one edge after it is presented.
- A disabled parallel port stays invalid and silent.
- Zero interrupt fields resolve to their defaults.

The bench scenarios show the rest:
- The exact fallback address of each function.
- The change between the 4-byte and 8-byte parallel windows.
- The A10 window and its dependence on the extended-mode enable.
- The floppy-over-serial priority where their windows overlap.
- The serial A over serial B priority when both share one base.
- The values held during reset.

// File: rtl/periph_dec_pkg.sv
package periph_dec_pkg;

   // Width of one configuration byte.
   localparam int CFG_W = 8;

   // Order of the chip select priority chain: entry 0 wins.
   typedef enum logic [1:0] {
      DEV_FDC    = 2'd0,
      DEV_UART_A = 2'd1,
      DEV_UART_B = 2'd2,
      DEV_LPT    = 2'd3
   } dev_e;

   localparam int NUM_DEV = 4;

   // Registered parallel mode.
   typedef struct packed {
      logic wide;   // 8-byte window
      logic ext;    // extra window with the high address bit set
   } lpt_mode_t;

endpackage

// File: rtl/pbd_base_form.sv
// Builds one base address from a configuration byte: shift, align, range-check, fallback.
module pbd_base_form #(
   parameter int              ADDR_W       = 11,
   parameter int              CFG_W        = 8,
   parameter int              SHIFT        = 2,
   parameter int              ALIGN_NARROW = 2,
   parameter int              ALIGN_WIDE   = 3,
   parameter logic [ADDR_W-1:0] LO         = 'h100,
   parameter logic [ADDR_W-1:0] HI         = 'h3FF,
   parameter logic [ADDR_W-1:0] FALLBACK   = 'h378
) (
   input  logic [CFG_W-1:0]  cfg_byte,
   input  logic              wide,
   output logic [ADDR_W-1:0] base
);

   localparam logic [ADDR_W-1:0] ONE    = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] MASK_N = ~((ONE << ALIGN_NARROW) - ONE);
   localparam logic [ADDR_W-1:0] MASK_W = ~((ONE << ALIGN_WIDE) - ONE);

   if (CFG_W + SHIFT > ADDR_W) begin : g_bad_width
      $error("pbd_base_form: shifted byte does not fit the address width");
   end
   if (ALIGN_WIDE < ALIGN_NARROW) begin : g_bad_align
      $error("pbd_base_form: wide alignment must not be finer than narrow");
   end

   logic [ADDR_W-1:0] raw;
   logic [ADDR_W-1:0] aligned;
   logic              in_range;

   always_comb begin
      raw      = ADDR_W'(cfg_byte) << SHIFT;
      aligned  = raw & (wide ? MASK_W : MASK_N);
      in_range = (aligned >= LO) && (aligned <= HI);
      base     = in_range ? aligned : FALLBACK;
   end

endmodule

// File: rtl/pbd_irq_pick.sv
// Resolves one interrupt number: a zero gate field substitutes ZERO_VAL, invalid gives NONE.
module pbd_irq_pick #(
   parameter int IRQ_W    = 4,
   parameter int GATE_W   = 4,
   parameter int ZERO_VAL = 15
) (
   input  logic [IRQ_W-1:0]  num,
   input  logic [GATE_W-1:0] gate,
   input  logic              valid,
   output logic [IRQ_W-1:0]  irq
);

   localparam logic [IRQ_W-1:0] NONE = '1;
   localparam logic [IRQ_W-1:0] ZV   = IRQ_W'(ZERO_VAL);

   if (ZERO_VAL >= (1 << IRQ_W)) begin : g_bad_zero
      $error("pbd_irq_pick: substitute value does not fit the interrupt width");
   end

   logic [IRQ_W-1:0] resolved;

   always_comb begin
      resolved = (gate == '0) ? ZV : num;
      irq      = valid ? resolved : NONE;
   end

endmodule

// File: rtl/pbd_win_match.sv
// Address window compare; the window size follows the alignment variant in use.
module pbd_win_match #(
   parameter int ADDR_W       = 11,
   parameter int ALIGN_NARROW = 2,
   parameter int ALIGN_WIDE   = 3
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] base,
   input  logic              wide,
   input  logic              en,
   output logic              hit
);

   localparam logic [ADDR_W-1:0] ONE    = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] MASK_N = ~((ONE << ALIGN_NARROW) - ONE);
   localparam logic [ADDR_W-1:0] MASK_W = ~((ONE << ALIGN_WIDE) - ONE);

   logic [ADDR_W-1:0] mask;

   if (ALIGN_WIDE == ALIGN_NARROW) begin : g_fixed
      logic unused_wide;
      assign unused_wide = wide;
      assign mask        = MASK_N;
   end else begin : g_mode
      assign mask = wide ? MASK_W : MASK_N;
   end

   assign hit = en && (((addr ^ base) & mask) == '0);

endmodule

// File: rtl/periph_base_decoder.sv
module periph_base_decoder
   import periph_dec_pkg::*;
#(
   parameter int              ADDR_W        = 11,
   parameter int              IRQ_W         = 4,
   parameter int              EXT_BIT       = 10,
   parameter int              FDC_ALIGN     = 4,
   parameter int              UART_ALIGN    = 3,
   parameter int              LPT_ALIGN_STD = 2,
   parameter int              LPT_ALIGN_EPP = 3,
   parameter logic [ADDR_W-1:0] RANGE_LO    = 'h100,
   parameter logic [ADDR_W-1:0] FDC_HI      = 'h3F0,
   parameter logic [ADDR_W-1:0] LPT_HI      = 'h3FF,
   parameter logic [ADDR_W-1:0] UART_HI     = 'h3F8,
   parameter logic [ADDR_W-1:0] FDC_DEF     = 'h3F0,
   parameter logic [ADDR_W-1:0] LPT_DEF     = 'h378,
   parameter logic [ADDR_W-1:0] UA_DEF      = 'h3F8,
   parameter logic [ADDR_W-1:0] UB_DEF      = 'h2F8,
   parameter int              UA_IRQ_DEF    = 4,
   parameter int              UB_IRQ_DEF    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        cfg_fdc_base,
   input  logic [7:0]        cfg_lpt_base,
   input  logic [7:0]        cfg_uart_a_base,
   input  logic [7:0]        cfg_uart_b_base,
   input  logic              cfg_ext_en,
   input  logic              cfg_epp_sel,
   input  logic              cfg_ecp_sel,
   input  logic              cfg_lpt_dis,
   input  logic              cfg_uart_a_dis,
   input  logic              cfg_uart_b_dis,
   input  logic [7:0]        cfg_uart_irq,
   input  logic [7:0]        cfg_lpt_irq,
   input  logic [ADDR_W-1:0] host_addr,
   output logic [ADDR_W-1:0] fdc_base,
   output logic [ADDR_W-1:0] lpt_base,
   output logic [ADDR_W-1:0] uart_a_base,
   output logic [ADDR_W-1:0] uart_b_base,
   output logic              fdc_valid,
   output logic              lpt_valid,
   output logic              uart_a_valid,
   output logic              uart_b_valid,
   output logic [IRQ_W-1:0]  lpt_irq,
   output logic [IRQ_W-1:0]  uart_a_irq,
   output logic [IRQ_W-1:0]  uart_b_irq,
   output logic              cs_fdc,
   output logic              cs_uart_a,
   output logic              cs_uart_b,
   output logic              cs_lpt
);

   localparam int               NIB    = CFG_W / 2;
   localparam logic [IRQ_W-1:0] NO_IRQ = '1;
   localparam logic [ADDR_W-1:0] EXT_OFS = ADDR_W'(1) << EXT_BIT;
   localparam int               LPT_NUM_W = 3;

   // ---------------- elaboration checks ----------------
   if (ADDR_W <= EXT_BIT) begin : g_chk_ext
      $error("periph_base_decoder: address width cannot carry the extra window bit");
   end
   if (IRQ_W < NIB) begin : g_chk_irq
      $error("periph_base_decoder: interrupt width narrower than a nibble");
   end
   if (LPT_ALIGN_EPP <= LPT_ALIGN_STD) begin : g_chk_lpt
      $error("periph_base_decoder: EPP window must be larger than standard");
   end
   if (ADDR_W < CFG_W + 2) begin : g_chk_addr
      $error("periph_base_decoder: address width too small for shifted bytes");
   end

   // ---------------- next-state decode ----------------
   lpt_mode_t         lpt_mode_d;
   logic [ADDR_W-1:0] fdc_base_d, lpt_base_d, ua_base_d, ub_base_d;
   logic              lpt_valid_d, ua_valid_d, ub_valid_d;
   logic [IRQ_W-1:0]  lpt_irq_d, ua_irq_d, ub_irq_d;

   always_comb begin
      lpt_mode_d.wide = cfg_ext_en & cfg_epp_sel;
      lpt_mode_d.ext  = cfg_ext_en & cfg_ecp_sel;
      lpt_valid_d     = ~cfg_lpt_dis;
      ua_valid_d      = ~cfg_uart_a_dis & (cfg_uart_a_base[7:6] != 2'b00);
      ub_valid_d      = ~cfg_uart_b_dis & (cfg_uart_b_base[7:6] != 2'b00);
   end

   pbd_base_form #(
      .ADDR_W(ADDR_W), .CFG_W(CFG_W), .SHIFT(2),
      .ALIGN_NARROW(FDC_ALIGN), .ALIGN_WIDE(FDC_ALIGN),
      .LO(RANGE_LO), .HI(FDC_HI), .FALLBACK(FDC_DEF)
   ) u_fdc_form (
      .cfg_byte(cfg_fdc_base), .wide(1'b0), .base(fdc_base_d)
   );

   pbd_base_form #(
      .ADDR_W(ADDR_W), .CFG_W(CFG_W), .SHIFT(2),
      .ALIGN_NARROW(LPT_ALIGN_STD), .ALIGN_WIDE(LPT_ALIGN_EPP),
      .LO(RANGE_LO), .HI(LPT_HI), .FALLBACK(LPT_DEF)
   ) u_lpt_form (
      .cfg_byte(cfg_lpt_base), .wide(lpt_mode_d.wide), .base(lpt_base_d)
   );

   pbd_base_form #(
      .ADDR_W(ADDR_W), .CFG_W(CFG_W), .SHIFT(2),
      .ALIGN_NARROW(UART_ALIGN), .ALIGN_WIDE(UART_ALIGN),
      .LO(RANGE_LO), .HI(UART_HI), .FALLBACK(UA_DEF)
   ) u_ua_form (
      .cfg_byte(cfg_uart_a_base), .wide(1'b0), .base(ua_base_d)
   );

   pbd_base_form #(
      .ADDR_W(ADDR_W), .CFG_W(CFG_W), .SHIFT(2),
      .ALIGN_NARROW(UART_ALIGN), .ALIGN_WIDE(UART_ALIGN),
      .LO(RANGE_LO), .HI(UART_HI), .FALLBACK(UB_DEF)
   ) u_ub_form (
      .cfg_byte(cfg_uart_b_base), .wide(1'b0), .base(ub_base_d)
   );

   pbd_irq_pick #(
      .IRQ_W(IRQ_W), .GATE_W(NIB), .ZERO_VAL(UA_IRQ_DEF)
   ) u_ua_irq (
      .num(IRQ_W'(cfg_uart_irq[CFG_W-1:NIB])), .gate(cfg_uart_irq[CFG_W-1:NIB]),
      .valid(ua_valid_d), .irq(ua_irq_d)
   );

   pbd_irq_pick #(
      .IRQ_W(IRQ_W), .GATE_W(NIB), .ZERO_VAL(UB_IRQ_DEF)
   ) u_ub_irq (
      .num(IRQ_W'(cfg_uart_irq[NIB-1:0])), .gate(cfg_uart_irq[NIB-1:0]),
      .valid(ub_valid_d), .irq(ub_irq_d)
   );

   pbd_irq_pick #(
      .IRQ_W(IRQ_W), .GATE_W(NIB), .ZERO_VAL(int'(NO_IRQ))
   ) u_lpt_irq (
      .num(IRQ_W'(cfg_lpt_irq[CFG_W-1:CFG_W-LPT_NUM_W])), .gate(cfg_lpt_irq[NIB-1:0]),
      .valid(lpt_valid_d), .irq(lpt_irq_d)
   );

   // cfg_lpt_irq[4] carries no meaning for this block
   logic unused_lpt_bit;
   assign unused_lpt_bit = cfg_lpt_irq[NIB];

   // ---------------- registered decode ----------------
   lpt_mode_t         lpt_mode_q;
   logic [ADDR_W-1:0] fdc_base_q, lpt_base_q, ua_base_q, ub_base_q;
   logic              lpt_valid_q, ua_valid_q, ub_valid_q;
   logic [IRQ_W-1:0]  lpt_irq_q, ua_irq_q, ub_irq_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fdc_base_q  <= FDC_DEF;
         lpt_base_q  <= LPT_DEF;
         ua_base_q   <= UA_DEF;
         ub_base_q   <= UB_DEF;
         lpt_mode_q  <= '0;
         lpt_valid_q <= 1'b1;
         ua_valid_q  <= 1'b1;
         ub_valid_q  <= 1'b1;
         lpt_irq_q   <= NO_IRQ;
         ua_irq_q    <= IRQ_W'(UA_IRQ_DEF);
         ub_irq_q    <= IRQ_W'(UB_IRQ_DEF);
      end else begin
         fdc_base_q  <= fdc_base_d;
         lpt_base_q  <= lpt_base_d;
         ua_base_q   <= ua_base_d;
         ub_base_q   <= ub_base_d;
         lpt_mode_q  <= lpt_mode_d;
         lpt_valid_q <= lpt_valid_d;
         ua_valid_q  <= ua_valid_d;
         ub_valid_q  <= ub_valid_d;
         lpt_irq_q   <= lpt_irq_d;
         ua_irq_q    <= ua_irq_d;
         ub_irq_q    <= ub_irq_d;
      end
   end

   // ---------------- window compare ----------------
   logic hit_fdc, hit_ua, hit_ub, hit_lpt_main, hit_lpt_ext;

   pbd_win_match #(.ADDR_W(ADDR_W), .ALIGN_NARROW(FDC_ALIGN), .ALIGN_WIDE(FDC_ALIGN))
   u_fdc_win (.addr(host_addr), .base(fdc_base_q), .wide(1'b0), .en(1'b1), .hit(hit_fdc));

   pbd_win_match #(.ADDR_W(ADDR_W), .ALIGN_NARROW(UART_ALIGN), .ALIGN_WIDE(UART_ALIGN))
   u_ua_win (.addr(host_addr), .base(ua_base_q), .wide(1'b0), .en(ua_valid_q), .hit(hit_ua));

   pbd_win_match #(.ADDR_W(ADDR_W), .ALIGN_NARROW(UART_ALIGN), .ALIGN_WIDE(UART_ALIGN))
   u_ub_win (.addr(host_addr), .base(ub_base_q), .wide(1'b0), .en(ub_valid_q), .hit(hit_ub));

   pbd_win_match #(.ADDR_W(ADDR_W), .ALIGN_NARROW(LPT_ALIGN_STD), .ALIGN_WIDE(LPT_ALIGN_EPP))
   u_lpt_win (.addr(host_addr), .base(lpt_base_q), .wide(lpt_mode_q.wide),
              .en(lpt_valid_q), .hit(hit_lpt_main));

   pbd_win_match #(.ADDR_W(ADDR_W), .ALIGN_NARROW(LPT_ALIGN_STD), .ALIGN_WIDE(LPT_ALIGN_EPP))
   u_lpt_ext_win (.addr(host_addr), .base(lpt_base_q | EXT_OFS), .wide(lpt_mode_q.wide),
                  .en(lpt_valid_q & lpt_mode_q.ext), .hit(hit_lpt_ext));

   // ---------------- priority chain ----------------
   logic [NUM_DEV-1:0] req, grant;

   always_comb begin
      req             = '0;
      req[DEV_FDC]    = hit_fdc;
      req[DEV_UART_A] = hit_ua;
      req[DEV_UART_B] = hit_ub;
      req[DEV_LPT]    = hit_lpt_main | hit_lpt_ext;
   end

   for (genvar i = 0; i < NUM_DEV; i++) begin : g_prio
      if (i == 0) begin : g_top
         assign grant[i] = req[i];
      end else begin : g_rest
         assign grant[i] = req[i] & ~(|req[i-1:0]);
      end
   end

   // ---------------- outputs ----------------
   assign fdc_base     = fdc_base_q;
   assign lpt_base     = lpt_base_q;
   assign uart_a_base  = ua_base_q;
   assign uart_b_base  = ub_base_q;
   assign fdc_valid    = 1'b1;
   assign lpt_valid    = lpt_valid_q;
   assign uart_a_valid = ua_valid_q;
   assign uart_b_valid = ub_valid_q;
   assign lpt_irq      = lpt_irq_q;
   assign uart_a_irq   = ua_irq_q;
   assign uart_b_irq   = ub_irq_q;
   assign cs_fdc       = grant[DEV_FDC];
   assign cs_uart_a    = grant[DEV_UART_A];
   assign cs_uart_b    = grant[DEV_UART_B];
   assign cs_lpt       = grant[DEV_LPT];

endmodule

// File: rtl/periph_base_decoder_chk.sv
module periph_base_decoder_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [7:0]  cfg_fdc_base,
   input logic        cfg_lpt_dis,
   input logic [7:0]  cfg_uart_irq,
   input logic [7:0]  cfg_lpt_irq,
   input logic [10:0] fdc_base,
   input logic        lpt_valid,
   input logic        uart_a_valid,
   input logic        uart_b_valid,
   input logic [3:0]  lpt_irq,
   input logic [3:0]  uart_a_irq,
   input logic        cs_fdc,
   input logic        cs_uart_a,
   input logic        cs_uart_b,
   input logic        cs_lpt
);

   // Set once the design has loaded its inputs on at least one edge out of reset.
   logic past_ok;
   always_ff @(posedge clk) past_ok <= rst_n;

   // R8: chip selects never overlap
   a_r8_cs_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cs_fdc, cs_uart_a, cs_uart_b, cs_lpt}));

   // R8 / R5: a select only for a valid serial port
   a_r8_cs_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_uart_a |-> uart_a_valid) and (cs_uart_b |-> uart_b_valid));

   // R1: floppy base aligned and inside its legal range
   a_r1_fdc_legal: assert property (@(posedge clk) disable iff (!rst_n)
      (fdc_base[3:0] == 4'h0) && (fdc_base >= 11'h100) && (fdc_base <= 11'h3F0));

   // R10: a legal floppy byte shows one edge later
   a_r10_fdc_follows: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && ($past(cfg_fdc_base[7:6]) != 2'b00) |-> fdc_base[9:4] == $past(cfg_fdc_base[7:2]));

   // R5: parallel disable clears valid and select
   a_r5_lpt_off: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && $past(cfg_lpt_dis) |-> !lpt_valid && !cs_lpt);

   // R6: zero serial A nibble resolves to 4
   a_r6_ua_zero_irq: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && ($past(cfg_uart_irq[7:4]) == 4'h0) && uart_a_valid |-> uart_a_irq == 4'd4);

   // R7: zero parallel enable field gives no interrupt
   a_r7_lpt_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && ($past(cfg_lpt_irq[3:0]) == 4'h0) |-> lpt_irq == 4'hF);

endmodule

bind periph_base_decoder periph_base_decoder_chk u_chk (.*);

// File: tb/periph_base_decoder_bench.sv
module periph_base_decoder_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  cfg_fdc_base = '0, cfg_lpt_base = '0, cfg_uart_a_base = '0, cfg_uart_b_base = '0;
   logic        cfg_ext_en = 0, cfg_epp_sel = 0, cfg_ecp_sel = 0;
   logic        cfg_lpt_dis = 0, cfg_uart_a_dis = 0, cfg_uart_b_dis = 0;
   logic [7:0]  cfg_uart_irq = '0, cfg_lpt_irq = '0;
   logic [10:0] host_addr = '0;
   logic [10:0] fdc_base, lpt_base, uart_a_base, uart_b_base;
   logic        fdc_valid, lpt_valid, uart_a_valid, uart_b_valid;
   logic [3:0]  lpt_irq, uart_a_irq, uart_b_irq;
   logic        cs_fdc, cs_uart_a, cs_uart_b, cs_lpt;

   always #10 clk = ~clk;   // 50 MHz

   periph_base_decoder u_periph_base_decoder (.*);

   int checks = 0;
   int failures = 0;
   bit done = 0;

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   typedef struct packed {
      logic [7:0]  fr, lr, ar, br;
      logic [5:0]  fl;   // ext, epp, ecp, lpt_dis, a_dis, b_dis
      logic [7:0]  ui, li;
      logic [10:0] ef, el, ea, eb;
      logic [3:0]  ev;   // fdc, lpt, a, b
      logic [3:0]  eia, eib, eil;
   } vec_t;

   localparam int NV = 6;
   localparam vec_t VECS [NV] = '{
      '{8'hFC, 8'hDE, 8'hFE, 8'hBE, 6'b000000, 8'h43, 8'h67, 11'h3F0, 11'h378, 11'h3F8, 11'h2F8, 4'b1111, 4'h4, 4'h3, 4'h3},
      '{8'h40, 8'h41, 8'h5F, 8'hC1, 6'b000000, 8'h00, 8'hE0, 11'h100, 11'h104, 11'h178, 11'h300, 4'b1111, 4'h4, 4'h3, 4'hF},
      '{8'h3C, 8'h3F, 8'h3E, 8'h20, 6'b000000, 8'h5A, 8'h21, 11'h3F0, 11'h378, 11'h3F8, 11'h2F8, 4'b1100, 4'hF, 4'hF, 4'h1},
      '{8'hFF, 8'hDB, 8'hFF, 8'h7F, 6'b110000, 8'h9C, 8'hFF, 11'h3F0, 11'h368, 11'h3F8, 11'h1F8, 4'b1111, 4'h9, 4'hC, 4'h7},
      '{8'hC0, 8'hDB, 8'hFE, 8'h80, 6'b010010, 8'h05, 8'h0F, 11'h300, 11'h36C, 11'h3F8, 11'h200, 4'b1101, 4'hF, 4'h5, 4'h0},
      '{8'h80, 8'hDE, 8'hFE, 8'hBE, 6'b000101, 8'h70, 8'h67, 11'h200, 11'h378, 11'h3F8, 11'h2F8, 4'b1010, 4'h7, 4'hF, 4'hF}
   };

   task automatic set_cfg(input logic [7:0] fr, lr, ar, br, input logic [5:0] fl,
                          input logic [7:0] ui, li);
      cfg_fdc_base = fr; cfg_lpt_base = lr; cfg_uart_a_base = ar; cfg_uart_b_base = br;
      {cfg_ext_en, cfg_epp_sel, cfg_ecp_sel, cfg_lpt_dis, cfg_uart_a_dis, cfg_uart_b_dis} = fl;
      cfg_uart_irq = ui; cfg_lpt_irq = li;
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic cs_at(input string req, input logic [10:0] a, input logic [3:0] exp);
      host_addr = a;
      #1;
      check(req, $sformatf("selects at 0x%0h", a), int'({cs_fdc, cs_uart_a, cs_uart_b, cs_lpt}), int'(exp));
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      // R9: defaults while reset is held, with hostile inputs present
      set_cfg(8'h00, 8'h00, 8'h00, 8'h00, 6'b111111, 8'h00, 8'h00);
      step(); step();
      check("R9", "fdc_base", int'(fdc_base), 'h3F0);
      check("R9", "lpt_base", int'(lpt_base), 'h378);
      check("R9", "uart_a_base", int'(uart_a_base), 'h3F8);
      check("R9", "uart_b_base", int'(uart_b_base), 'h2F8);
      check("R9", "valids", int'({fdc_valid, lpt_valid, uart_a_valid, uart_b_valid}), 'hF);
      check("R9", "irqs", int'({lpt_irq, uart_a_irq, uart_b_irq}), 'hF43);
      cs_at("R9", 11'h37C, 4'b0000);  // standard 4-byte parallel window
      cs_at("R9", 11'h77A, 4'b0000);  // no A10 window
      cs_at("R9", 11'h37B, 4'b0001);
      rst_n = 1'b1;

      // Table walk: R1 R2 R3 R4 R5 R6 R7
      for (int i = 0; i < NV; i++) begin
         set_cfg(VECS[i].fr, VECS[i].lr, VECS[i].ar, VECS[i].br, VECS[i].fl, VECS[i].ui, VECS[i].li);
         step();
         check("R1", $sformatf("v%0d fdc_base", i), int'(fdc_base), int'(VECS[i].ef));
         check("R2", $sformatf("v%0d lpt_base", i), int'(lpt_base), int'(VECS[i].el));
         check("R4", $sformatf("v%0d uart_a_base", i), int'(uart_a_base), int'(VECS[i].ea));
         check("R4", $sformatf("v%0d uart_b_base", i), int'(uart_b_base), int'(VECS[i].eb));
         check("R5", $sformatf("v%0d valids", i),
               int'({fdc_valid, lpt_valid, uart_a_valid, uart_b_valid}), int'(VECS[i].ev));
         check("R6", $sformatf("v%0d uart_a_irq", i), int'(uart_a_irq), int'(VECS[i].eia));
         check("R6", $sformatf("v%0d uart_b_irq", i), int'(uart_b_irq), int'(VECS[i].eib));
         check("R7", $sformatf("v%0d lpt_irq", i), int'(lpt_irq), int'(VECS[i].eil));
      end

      // R8 R3: ECP window on, floppy window overlaps serial A
      set_cfg(8'hFC, 8'hDE, 8'hFE, 8'hBE, 6'b101000, 8'h43, 8'h67);
      step();
      cs_at("R8", 11'h3F8, 4'b1000);
      cs_at("R8", 11'h37B, 4'b0001);
      cs_at("R3", 11'h77A, 4'b0001);
      cs_at("R2", 11'h37C, 4'b0000);
      cs_at("R8", 11'h2FF, 4'b0010);
      cs_at("R8", 11'h300, 4'b0000);

      // R3: EPP window, floppy moved away
      set_cfg(8'h40, 8'hDE, 8'hFE, 8'hBE, 6'b110000, 8'h43, 8'h67);
      step();
      cs_at("R8", 11'h3FA, 4'b0100);
      cs_at("R3", 11'h37C, 4'b0001);
      cs_at("R3", 11'h77A, 4'b0000);
      cs_at("R1", 11'h10F, 4'b1000);

      // R8 R5: serial ports share a base, parallel disabled
      set_cfg(8'h40, 8'hDE, 8'hBE, 8'hBE, 6'b000100, 8'h43, 8'h67);
      step();
      cs_at("R8", 11'h2F9, 4'b0100);
      cs_at("R5", 11'h378, 4'b0000);

      // R3: mode selects without the extended enable are ignored
      set_cfg(8'h40, 8'hDE, 8'hFE, 8'hBE, 6'b011000, 8'h43, 8'h67);
      step();
      cs_at("R3", 11'h37C, 4'b0000);
      cs_at("R3", 11'h77A, 4'b0000);
      check("R3", "lpt_base", int'(lpt_base), 'h378);

      // R10: one-edge latency
      cfg_fdc_base = 8'h80;
      #2;
      check("R10", "fdc_base before edge", int'(fdc_base), 'h100);
      step();
      check("R10", "fdc_base after edge", int'(fdc_base), 'h200);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule